// File: doc/BRIEF.md
# Circular Capture Trigger Controller

This block sequences one capture of a four-channel sampling logic analyzer whose sample memory writes in an endless wrap-around loop. After an arm command it opens exactly one sample clock path, either the full-rate gated oscillator path or a divided path. On every sample it produces a one-cycle sample enable. It keeps its own address count in step with the memory, because the memory's write pointer cannot be read back. That count moves in units of four samples: a two-bit prescaler feeds a narrow address counter.

A trigger unit compares each new sample of the channel inputs with the previous one. A change on any channel enabled in the trigger mask fires it. The controller then loads a post-trigger countdown, which is also counted in units of four samples. When the countdown expires it closes the clock path and raises a done flag. From the final address count it presents the readout start address. That address is the location of the oldest sample, so a dump beginning there comes out oldest first.

All pins are plain control and status signals that are sampled or driven each clock. There is no streaming data interface, so no valid/ready handshake or back-pressure applies. Configuration is taken when arm is asserted and held for the whole capture.

Top module: `capture_trig_ctrl`

## Requirements
- R1: After reset, and until the first arm, osc_gate_en, div_gate_en and samp_en are 0, cap_done is 0 and rd_start_addr is 0.
- R2: While capturing, exactly one clock path is open. It is osc_gate_en when cfg_fast was 1 at arm, otherwise div_gate_en. The two are never high together.
- R3: On the oscillator path samp_en is high every cycle of the capture. On the divided path samp_en pulses once every cfg_div+1 cycles, and the first pulse comes cfg_div+1 cycles after arm.
- R4: The trigger fires on a sample where any channel whose cfg_mask bit is 1 differs from the previous sample. Changes on channels whose mask bit is 0 never fire it, and a mask of 0 lets capture run indefinitely.
- R5: The first sample after arm is never compared, so a difference between the inputs before arm and that first sample does not fire the trigger.
- R6: Numbering samples from 0 at arm, a prescaled tick is any sample whose index mod 4 is 3. With trigger at sample k and post count P, the final sample is the (P+1)-th prescaled tick strictly after k. A count of 0 therefore stops on the first prescaled tick after the trigger.
- R7: Trigger conditions that occur during the post-trigger countdown have no effect on when capture stops.
- R8: In the cycle after the final sample, samp_en and both gate enables are 0 and cap_done is 1. They stay that way until the next arm.
- R9: At stop, rd_start_addr equals the total number of samples written since arm, modulo the buffer depth 2^(CNT_W+2). This equals four times the final address count, so the value wraps with the buffer.
- R10: Arm clears cap_done within one cycle, restarts the address count at 0 and latches cfg_fast, cfg_div, cfg_mask and cfg_post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; also the full-rate sample timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that starts a new capture |
| cfg_fast | input | 1 | 1 selects the oscillator path, 0 the divided path |
| cfg_div | input | DIV_W | Divided path period minus one, in clk cycles |
| cfg_mask | input | CH | Per-channel trigger enable |
| cfg_post | input | CNT_W | Post-trigger length in units of four samples |
| chan_in | input | CH | Channel input levels |
| osc_gate_en | output | 1 | Opens the oscillator clock path |
| div_gate_en | output | 1 | Opens the divided clock path |
| samp_en | output | 1 | Sample strobe to the memory for this cycle |
| cap_done | output | 1 | Capture finished, clock paths closed |
| rd_start_addr | output | CNT_W+2 | Address of the oldest stored sample |

## Verification
The bench builds the block with CNT_W set to 8, which gives a 1024-sample buffer. Post-trigger lengths of a few hundred units then carry the address count past the buffer end, so the wrap of the readout address is exercised within the cycle budget. CH stays at 4 and DIV_W at 8. Divider settings of 0 to 3 keep the divided path's pulse spacing short enough to check every interval. Trigger positions at every phase of the prescaler show whether the countdown starts on the right tick.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_rate_gen.sv
module cap_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic             use_fast,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             osc_gate_en,
  output logic             div_gate_en,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt_q;
  logic             div_hit;

  assign div_hit = (dcnt_q == div_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt_q <= '0;
    else if (restart || !active || use_fast) dcnt_q <= '0;
    else if (div_hit) dcnt_q <= '0;
    else dcnt_q <= dcnt_q + 1'b1;
  end

  // one source only: selection is a single latched bit
  assign osc_gate_en = active && use_fast;
  assign div_gate_en = active && !use_fast;
  assign tick = osc_gate_en || (div_gate_en && div_hit);
endmodule

// File: rtl/cap_edge_trig.sv
module cap_edge_trig #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          samp_en,
  input  logic [CH-1:0] chan_in,
  input  logic [CH-1:0] mask,
  output logic          fire
);
  logic [CH-1:0] prev_q;
  logic          have_prev_q;
  logic [CH-1:0] diff;

  always_comb begin
    for (int i = 0; i < CH; i++) diff[i] = (chan_in[i] ^ prev_q[i]) & mask[i];
  end

  assign fire = samp_en && have_prev_q && (|diff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (restart) begin
      have_prev_q <= 1'b0;
    end else if (samp_en) begin
      prev_q      <= chan_in;
      have_prev_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_addr_track.sv
module cap_addr_track #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   samp_en,
  output logic                   pre_tick,
  output logic [CNT_W+PRE_W-1:0] rd_start
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] addr_q;

  assign pre_tick = samp_en && (pre_q == PRE_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q  <= '0;
      addr_q <= '0;
    end else if (samp_en) begin
      pre_q <= pre_q + 1'b1;
      if (pre_tick) addr_q <= addr_q + 1'b1;
    end
  end

  assign rd_start = {addr_q, {PRE_W{1'b0}}};
endmodule

// File: rtl/cap_post_cnt.sv
module cap_post_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_tick,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec_tick && !cnt_zero) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/capture_trig_ctrl.sv
module capture_trig_ctrl
  import cap_pkg::*;
#(
  parameter int CH    = 4,
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               cfg_fast,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [CH-1:0]      cfg_mask,
  input  logic [CNT_W-1:0]   cfg_post,
  input  logic [CH-1:0]      chan_in,
  output logic               osc_gate_en,
  output logic               div_gate_en,
  output logic               samp_en,
  output logic               cap_done,
  output logic [CNT_W+1:0]   rd_start_addr
);
  localparam int PRE_W = 2;

  cap_state_e       state_q, state_d;
  logic             fast_q;
  logic [DIV_W-1:0] div_q;
  logic [CH-1:0]    mask_q;
  logic [CNT_W-1:0] post_q;
  logic             active, tick, fire, pre_tick, cnt_zero, load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      div_q  <= '0;
      mask_q <= '0;
      post_q <= '0;
    end else if (arm) begin
      fast_q <= cfg_fast;
      div_q  <= cfg_div;
      mask_q <= cfg_mask;
      post_q <= cfg_post;
    end
  end

  assign active = (state_q == ST_RUN) || (state_q == ST_POST);
  assign load   = (state_q == ST_RUN) && fire;

  always_comb begin
    state_d = state_q;
    if (arm) state_d = ST_RUN;
    else begin
      case (state_q)
        ST_RUN:  if (fire) state_d = ST_POST;
        ST_POST: if (pre_tick && cnt_zero) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  cap_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .restart(arm), .active(active),
    .use_fast(fast_q), .div_cfg(div_q),
    .osc_gate_en(osc_gate_en), .div_gate_en(div_gate_en), .tick(tick)
  );

  assign samp_en = tick;

  cap_edge_trig #(.CH(CH)) u_trig (
    .clk(clk), .rst_n(rst_n), .restart(arm), .samp_en(samp_en),
    .chan_in(chan_in), .mask(mask_q), .fire(fire)
  );

  cap_addr_track #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart(arm), .samp_en(samp_en),
    .pre_tick(pre_tick), .rd_start(rd_start_addr)
  );

  cap_post_cnt #(.CNT_W(CNT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(post_q),
    .dec_tick(pre_tick && (state_q == ST_POST)), .cnt_zero(cnt_zero)
  );

  assign cap_done = (state_q == ST_DONE);
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             osc_gate_en,
  input logic             div_gate_en,
  input logic             samp_en,
  input logic             cap_done,
  input logic [CNT_W+1:0] rd_start_addr
);
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_gate_en && div_gate_en));

  a_r3_fast_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    osc_gate_en |-> samp_en);

  a_r8_done_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> (!samp_en && !osc_gate_en && !div_gate_en));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !arm) |=> cap_done);

  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !cap_done);

  a_r9_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en && !arm) |=> $stable(rd_start_addr));
endmodule

bind capture_trig_ctrl cap_checker #(.CNT_W(CNT_W)) u_cap_checker (
  .clk(clk), .rst_n(rst_n), .arm(arm), .osc_gate_en(osc_gate_en),
  .div_gate_en(div_gate_en), .samp_en(samp_en), .cap_done(cap_done),
  .rd_start_addr(rd_start_addr)
);

// File: tb/capture_trig_ctrl_bench.sv
module capture_trig_ctrl_bench;
  localparam int CH    = 4;
  localparam int CNT_W = 8;
  localparam int DIV_W = 8;
  localparam int AW    = CNT_W + 2;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             arm = 1'b0;
  logic             cfg_fast = 1'b1;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [CH-1:0]    cfg_mask = '0;
  logic [CNT_W-1:0] cfg_post = '0;
  logic [CH-1:0]    chan_in = '0;
  logic             osc_gate_en, div_gate_en, samp_en, cap_done;
  logic [AW-1:0]    rd_start_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  capture_trig_ctrl #(.CH(CH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_capture_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_fast(cfg_fast), .cfg_div(cfg_div),
    .cfg_mask(cfg_mask), .cfg_post(cfg_post), .chan_in(chan_in),
    .osc_gate_en(osc_gate_en), .div_gate_en(div_gate_en), .samp_en(samp_en),
    .cap_done(cap_done), .rd_start_addr(rd_start_addr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // index of final sample per R6
  function automatic int exp_last(input int k, input int post);
    int p0;
    p0 = ((k % 4) == 3) ? k + 4 : (k | 3);
    return p0 + 4 * post;
  endfunction

  function automatic logic [CH-1:0] pat(input int i, input int trig,
                                        input logic [CH-1:0] base,
                                        input logic [CH-1:0] msk,
                                        input logic [CH-1:0] flip);
    if (i < trig) return (base & msk) | (CH'($urandom) & ~msk);
    if (i == trig) return base ^ flip;
    return CH'($urandom); // R7: later changes must not matter
  endfunction

  task automatic arm_cfg(input logic fast, input int div, input logic [CH-1:0] msk,
                         input int post, input logic [CH-1:0] pre_val);
    @(negedge clk);
    chan_in  = pre_val;
    cfg_fast = fast;
    cfg_div  = DIV_W'(div);
    cfg_mask = msk;
    cfg_post = CNT_W'(post);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    cfg_mask = ~msk; // R10: later changes to config must be ignored
    cfg_post = ~CNT_W'(post);
    cfg_div  = ~DIV_W'(div);
    cfg_fast = ~fast;
  endtask

  task automatic run_cap(input logic fast, input int div, input logic [CH-1:0] msk,
                         input int post, input int trig, input string tag);
    logic [CH-1:0] base, flip;
    int nsamp, cyc, last_cyc, bad_gap, exp_gap, hit;
    base = CH'($urandom);
    flip = msk & CH'($urandom);
    if (flip == '0) begin
      for (int b = 0; b < CH; b++) if (msk[b] && flip == '0) flip[b] = 1'b1;
    end
    // R5: value before arm differs from sample 0 on masked channels
    arm_cfg(fast, div, msk, post, (base ^ msk));
    check({tag, " R10 done cleared"}, cap_done, 0);
    check({tag, " R2 osc gate"}, osc_gate_en, fast);
    check({tag, " R2 div gate"}, div_gate_en, !fast);
    nsamp = 0; cyc = 0; last_cyc = -1; bad_gap = 0; hit = 0;
    exp_gap = fast ? 1 : div + 1;
    while (cyc < 20000) begin
      if (cap_done) begin hit = 1; break; end
      chan_in = pat(nsamp, trig, base, msk, flip);
      if (samp_en) begin
        if (last_cyc < 0) begin
          if (cyc + 1 != exp_gap) bad_gap++;
        end else if (cyc - last_cyc != exp_gap) bad_gap++;
        last_cyc = cyc;
        nsamp++;
      end
      cyc++;
      @(negedge clk);
    end
    check({tag, " R8 done reached"}, hit, 1);
    check({tag, " R3 sample spacing errors"}, bad_gap, 0);
    check({tag, " R6 samples written"}, nsamp, exp_last(trig, post) + 1);
    check({tag, " R9 readout start"}, rd_start_addr, (exp_last(trig, post) + 1) % DEPTH);
    repeat (3) @(negedge clk);
    check({tag, " R8 stays stopped"}, {cap_done, samp_en, osc_gate_en, div_gate_en}, 4'b1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle gates/strobe/done", {osc_gate_en, div_gate_en, samp_en, cap_done}, 0);
    check("R1 idle readout", rd_start_addr, 0);

    // directed: R6 zero post at each prescaler phase
    run_cap(1'b1, 0, 4'b0001, 0, 1, "d1");
    run_cap(1'b1, 0, 4'b0010, 0, 3, "d2");
    run_cap(1'b1, 0, 4'b1000, 0, 7, "d3");
    run_cap(1'b0, 2, 4'b0100, 1, 2, "d4");
    // R9 wrap past buffer end
    run_cap(1'b1, 0, 4'b1111, 255, 20, "d5");

    // R4 mask zero: never triggers
    arm_cfg(1'b1, 0, 4'b0000, 0, 4'b0000);
    for (int i = 0; i < 300; i++) begin
      chan_in = CH'($urandom);
      @(negedge clk);
    end
    check("R4 mask zero keeps running", {cap_done, samp_en}, 2'b01);

    // random runs
    for (int r = 0; r < 12; r++) begin
      logic f;
      int dv, ps, tg;
      logic [CH-1:0] m;
      f  = 1'($urandom);
      dv = $urandom_range(0, 3);
      m  = CH'($urandom);
      if (m == '0) m = 4'b0100;
      ps = $urandom_range(0, 280 < (1 << CNT_W) ? 255 : 255);
      tg = $urandom_range(1, 60);
      run_cap(f, dv, m, ps, tg, $sformatf("rnd%0d", r));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule